// File: doc/BRIEF.md
# Load Miss Tracker with Block Merging

This block follows data-cache load misses until the lower memory level returns the missing line. Each tracked entry holds one 32-byte block address, together with up to four loads that wait on that block. For each load the entry keeps the destination register, the load's format code and the byte offset within its quadword.

When a new miss arrives, it is compared against every pending entry. A miss to a block that already has an unfilled entry joins that entry, as long as its 8-byte slot is still unused there, and it causes no new memory traffic. Otherwise the miss takes a free entry, and that entry issues exactly one fill request. Requests leave in the order the entries were allocated.

When a fill returns, the block reports every load held in that entry, one load per cycle. Each report carries the quadword that the load selects from the line. After the last report the entry is released.

Top module: `loadMissFile`

## Requirements
- R1: After reset, `reqValid`, `cmplValid` and `missStall` are low, `fillReady` is high, and all six entries are free.
- R2: A miss that cannot merge and finds a free entry takes the lowest-numbered free entry (ids 0 to 5). One cycle later that entry appears as a request: `reqId` is the entry id and `reqAddr` is the miss address with bits [4:0] cleared.
- R3: A miss whose address bits [39:5] equal those of a valid, not yet filled entry, and whose slot (address bits [4:3]) is unused in that entry, joins the lowest such entry. It raises no new request and no stall.
- R4: A miss whose slot is already used in the matching entry does not merge. It takes a new entry and a new request, so an entry never holds more than four loads.
- R5: When all six entries are valid and the miss cannot merge, `missStall` is high in the same cycle as `missValid`, and the miss is not recorded.
- R6: Pending requests are presented oldest allocation first. `reqValid`, `reqId` and `reqAddr` stay unchanged until a cycle with `reqReady` high.
- R7: A fill accepted on a clock edge (`fillValid` and `fillReady` high, `fillId` naming a valid, unfilled entry) makes `cmplValid` high from the next cycle. It stays high for exactly as many consecutive cycles as the entry has loads, one load per cycle in arrival order. Each report carries the load's register, format, byte offset (address bits [2:0]) and `fillData[slot*64 +: 64]`.
- R8: `fillReady` is low while completions are being reported. The entry is free again in the cycle after its last completion.
- R9: Once its fill has been accepted, an entry takes no further merges. A later miss to the same block allocates a new entry.
- R10: A fill whose `fillId` names a free entry or an id of 6 or more is ignored and produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | A load miss is presented this cycle |
| missAddr | input | 40 | Byte address of the missing load |
| missReg | input | 5 | Destination register of the load |
| missFmt | input | 3 | Format code of the load |
| missStall | output | 1 | The miss cannot be accepted this cycle |
| reqValid | output | 1 | A fill request is pending toward the lower level |
| reqReady | input | 1 | Lower level takes the pending request |
| reqId | output | 3 | Entry id of the pending request |
| reqAddr | output | 40 | Block-aligned address of the pending request |
| fillValid | input | 1 | A line is returned |
| fillId | input | 3 | Entry id the line belongs to |
| fillData | input | 256 | Returned 32-byte line, quadword n in bits [64n+63:64n] |
| fillReady | output | 1 | A fill can be accepted this cycle |
| cmplValid | output | 1 | One waiting load is completed this cycle |
| cmplReg | output | 5 | Register of the completed load |
| cmplFmt | output | 3 | Format code of the completed load |
| cmplByte | output | 3 | Byte offset of the load within its quadword |
| cmplData | output | 64 | Quadword of the line selected by the load |

## Verification
The merge function is driven in four rotations. In each rotation four loads cover every slot of one block, starting at a different slot, and then a fifth load repeats the first slot. The completion order then separates arrival order from slot order, and the fifth load separates a slot conflict from a valid merge. A fill-up sweep occupies all six entries with distinct blocks and then offers a new block, a free slot and a used slot. This tells stall apart from merge when nothing is free. Further sequences hold `reqReady` low across three allocations to expose request order. They send a miss into a block whose fill is draining, and they return fills for free and out-of-range ids.

// File: rtl/lmfPkg.sv
package lmfPkg;
  localparam int ENTRIES    = 6;
  localparam int ADDR_W     = 40;
  localparam int REG_W      = 5;
  localparam int FMT_W      = 3;
  localparam int BLK_BYTES  = 32;
  localparam int WORD_BYTES = 8;

  localparam int OFF_W    = $clog2(BLK_BYTES);
  localparam int WORD_OFF = $clog2(WORD_BYTES);
  localparam int LOADS    = BLK_BYTES / WORD_BYTES;
  localparam int SLOT_W   = $clog2(LOADS);
  localparam int BLK_W    = ADDR_W - OFF_W;
  localparam int ID_W     = $clog2(ENTRIES);
  localparam int CNT_W    = $clog2(LOADS + 1);
  localparam int LINE_W   = BLK_BYTES * 8;
  localparam int WORD_W   = WORD_BYTES * 8;

  // strobes from control to datapath
  typedef struct packed {
    logic              alloc;
    logic              merge;
    logic [ID_W-1:0]   tgt;
    logic              fillTake;
    logic [ID_W-1:0]   drainId;
    logic [SLOT_W-1:0] drainIdx;
  } lmfStrobe_t;
endpackage

// File: rtl/lmfData.sv
module lmfData
  import lmfPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  lmfStrobe_t                    strb,
  input  logic [ADDR_W-1:0]             missAddr,
  input  logic [REG_W-1:0]              missReg,
  input  logic [FMT_W-1:0]              missFmt,
  input  logic [ID_W-1:0]               reqId,
  input  logic [LINE_W-1:0]             fillData,
  output logic [ENTRIES-1:0]            blkHit,
  output logic [ENTRIES-1:0]            slotFree,
  output logic [ENTRIES-1:0][CNT_W-1:0] loadCnt,
  output logic [ADDR_W-1:0]             reqAddr,
  output logic [REG_W-1:0]              cmplReg,
  output logic [FMT_W-1:0]              cmplFmt,
  output logic [WORD_OFF-1:0]           cmplByte,
  output logic [WORD_W-1:0]             cmplData
);
  logic [BLK_W-1:0]    missBlk;
  logic [SLOT_W-1:0]   missSlot;
  logic [WORD_OFF-1:0] missByte;

  assign missBlk  = missAddr[ADDR_W-1:OFF_W];
  assign missSlot = missAddr[OFF_W-1:WORD_OFF];
  assign missByte = missAddr[WORD_OFF-1:0];

  logic [BLK_W-1:0]                  blkArr  [ENTRIES];
  logic [LOADS-1:0][REG_W-1:0]       regArr  [ENTRIES];
  logic [LOADS-1:0][FMT_W-1:0]       fmtArr  [ENTRIES];
  logic [LOADS-1:0][SLOT_W-1:0]      slotArr [ENTRIES];
  logic [LOADS-1:0][WORD_OFF-1:0]    byteArr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
    logic [BLK_W-1:0]               blk;
    logic [LOADS-1:0]               mask;
    logic [CNT_W-1:0]               cnt;
    logic [LOADS-1:0][REG_W-1:0]    lReg;
    logic [LOADS-1:0][FMT_W-1:0]    lFmt;
    logic [LOADS-1:0][SLOT_W-1:0]   lSlot;
    logic [LOADS-1:0][WORD_OFF-1:0] lByte;
    logic selAlloc, selMerge;

    assign selAlloc = strb.alloc && (strb.tgt == ID_W'(e));
    assign selMerge = strb.merge && (strb.tgt == ID_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blk   <= '0;
        mask  <= '0;
        cnt   <= '0;
        lReg  <= '0;
        lFmt  <= '0;
        lSlot <= '0;
        lByte <= '0;
      end else if (selAlloc) begin
        blk      <= missBlk;
        mask     <= LOADS'(1) << missSlot;
        cnt      <= CNT_W'(1);
        lReg[0]  <= missReg;
        lFmt[0]  <= missFmt;
        lSlot[0] <= missSlot;
        lByte[0] <= missByte;
      end else if (selMerge) begin
        mask[missSlot]            <= 1'b1;
        cnt                       <= cnt + CNT_W'(1);
        lReg[cnt[SLOT_W-1:0]]     <= missReg;
        lFmt[cnt[SLOT_W-1:0]]     <= missFmt;
        lSlot[cnt[SLOT_W-1:0]]    <= missSlot;
        lByte[cnt[SLOT_W-1:0]]    <= missByte;
      end
    end

    assign blkHit[e]   = (blk == missBlk);
    assign slotFree[e] = ~mask[missSlot];
    assign loadCnt[e]  = cnt;
    assign blkArr[e]   = blk;
    assign regArr[e]   = lReg;
    assign fmtArr[e]   = lFmt;
    assign slotArr[e]  = lSlot;
    assign byteArr[e]  = lByte;
  end

  logic [LINE_W-1:0] lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lineQ <= '0;
    else if (strb.fillTake) lineQ <= fillData;
  end

  logic [SLOT_W-1:0] outSlot;

  assign reqAddr  = {blkArr[reqId], {OFF_W{1'b0}}};
  assign outSlot  = slotArr[strb.drainId][strb.drainIdx];
  assign cmplReg  = regArr[strb.drainId][strb.drainIdx];
  assign cmplFmt  = fmtArr[strb.drainId][strb.drainIdx];
  assign cmplByte = byteArr[strb.drainId][strb.drainIdx];
  assign cmplData = lineQ[int'(outSlot)*WORD_W +: WORD_W];
endmodule

// File: rtl/lmfCtrl.sv
module lmfCtrl
  import lmfPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          missValid,
  input  logic                          fillValid,
  input  logic [ID_W-1:0]               fillId,
  input  logic                          reqReady,
  input  logic [ENTRIES-1:0]            blkHit,
  input  logic [ENTRIES-1:0]            slotFree,
  input  logic [ENTRIES-1:0][CNT_W-1:0] loadCnt,
  output lmfStrobe_t                    strb,
  output logic                          missStall,
  output logic                          reqValid,
  output logic [ID_W-1:0]               reqId,
  output logic                          fillReady,
  output logic                          cmplValid,
  output logic [ENTRIES-1:0]            entValid
);
  localparam int QC_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] validQ, filledQ, canMerge;
  logic               mergeHit, anyFree;
  logic [ID_W-1:0]    mergeId, freeId;
  logic               busyQ, drainLast, fillTake, fillIdOk;
  logic [ID_W-1:0]    drainIdQ;
  logic [SLOT_W-1:0]  drainIdxQ;

  assign fillIdOk = int'(fillId) < ENTRIES;
  assign fillTake = fillValid && !busyQ && fillIdOk &&
                    validQ[fillId] && !filledQ[fillId];

  for (genvar e = 0; e < ENTRIES; e++) begin : gMatch
    assign canMerge[e] = validQ[e] && !filledQ[e] && blkHit[e] && slotFree[e] &&
                         !(fillTake && (fillId == ID_W'(e)));
  end

  // lowest-index pick for merge target and free entry
  always_comb begin
    mergeHit = 1'b0;
    mergeId  = '0;
    anyFree  = 1'b0;
    freeId   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (canMerge[e]) begin
        mergeHit = 1'b1;
        mergeId  = ID_W'(e);
      end
      if (!validQ[e]) begin
        anyFree = 1'b1;
        freeId  = ID_W'(e);
      end
    end
  end

  always_comb begin
    strb.merge    = missValid && mergeHit;
    strb.alloc    = missValid && !mergeHit && anyFree;
    strb.tgt      = mergeHit ? mergeId : freeId;
    strb.fillTake = fillTake;
    strb.drainId  = drainIdQ;
    strb.drainIdx = drainIdxQ;
  end

  assign missStall = missValid && !mergeHit && !anyFree;
  assign drainLast = (CNT_W'(drainIdxQ) == loadCnt[drainIdQ] - CNT_W'(1));
  assign fillReady = !busyQ;
  assign cmplValid = busyQ;
  assign entValid  = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      filledQ   <= '0;
      busyQ     <= 1'b0;
      drainIdQ  <= '0;
      drainIdxQ <= '0;
    end else begin
      if (strb.alloc) begin
        validQ[strb.tgt]  <= 1'b1;
        filledQ[strb.tgt] <= 1'b0;
      end
      if (fillTake) begin
        filledQ[fillId] <= 1'b1;
        busyQ           <= 1'b1;
        drainIdQ        <= fillId;
        drainIdxQ       <= '0;
      end else if (busyQ) begin
        if (drainLast) begin
          busyQ             <= 1'b0;
          validQ[drainIdQ]  <= 1'b0;
          filledQ[drainIdQ] <= 1'b0;
        end else begin
          drainIdxQ <= drainIdxQ + SLOT_W'(1);
        end
      end
    end
  end

  // request queue: entry ids in allocation order
  logic [ID_W-1:0] qMem [ENTRIES];
  logic [ID_W-1:0] headQ, tailQ;
  logic [QC_W-1:0] qCntQ;
  logic            push, pop;

  function automatic logic [ID_W-1:0] nextPtr(input logic [ID_W-1:0] p);
    return (p == ID_W'(ENTRIES - 1)) ? '0 : p + ID_W'(1);
  endfunction

  assign push     = strb.alloc;
  assign reqValid = (qCntQ != '0);
  assign reqId    = qMem[headQ];
  assign pop      = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (push) qMem[tailQ] <= strb.tgt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      qCntQ <= '0;
    end else begin
      if (push) tailQ <= nextPtr(tailQ);
      if (pop)  headQ <= nextPtr(headQ);
      qCntQ <= qCntQ + QC_W'(push) - QC_W'(pop);
    end
  end
endmodule

// File: rtl/loadMissFile.sv
module loadMissFile
  import lmfPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                missValid,
  input  logic [ADDR_W-1:0]   missAddr,
  input  logic [REG_W-1:0]    missReg,
  input  logic [FMT_W-1:0]    missFmt,
  output logic                missStall,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [ID_W-1:0]     reqId,
  output logic [ADDR_W-1:0]   reqAddr,
  input  logic                fillValid,
  input  logic [ID_W-1:0]     fillId,
  input  logic [LINE_W-1:0]   fillData,
  output logic                fillReady,
  output logic                cmplValid,
  output logic [REG_W-1:0]    cmplReg,
  output logic [FMT_W-1:0]    cmplFmt,
  output logic [WORD_OFF-1:0] cmplByte,
  output logic [WORD_W-1:0]   cmplData
);
  lmfStrobe_t                    strb;
  logic [ENTRIES-1:0]            blkHit, slotFree, entValid;
  logic [ENTRIES-1:0][CNT_W-1:0] loadCnt;

  lmfCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .missValid (missValid),
    .fillValid (fillValid),
    .fillId    (fillId),
    .reqReady  (reqReady),
    .blkHit    (blkHit),
    .slotFree  (slotFree),
    .loadCnt   (loadCnt),
    .strb      (strb),
    .missStall (missStall),
    .reqValid  (reqValid),
    .reqId     (reqId),
    .fillReady (fillReady),
    .cmplValid (cmplValid),
    .entValid  (entValid)
  );

  lmfData uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .missAddr (missAddr),
    .missReg  (missReg),
    .missFmt  (missFmt),
    .reqId    (reqId),
    .fillData (fillData),
    .blkHit   (blkHit),
    .slotFree (slotFree),
    .loadCnt  (loadCnt),
    .reqAddr  (reqAddr),
    .cmplReg  (cmplReg),
    .cmplFmt  (cmplFmt),
    .cmplByte (cmplByte),
    .cmplData (cmplData)
  );
endmodule

// File: rtl/lmfChk.sv
module lmfChk
  import lmfPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               missValid,
  input logic               missStall,
  input logic               reqValid,
  input logic               reqReady,
  input logic [ID_W-1:0]    reqId,
  input logic               fillReady,
  input logic               cmplValid,
  input logic [ENTRIES-1:0] entValid,
  input logic               allocS,
  input logic               mergeS,
  input logic               fillTakeS
);
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    missStall |-> (missValid && (&entValid))); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqId))); // R6

  AST_FILL_STARTS_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    fillTakeS |=> cmplValid); // R7

  AST_NO_FILL_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> !fillReady); // R8

  AST_MERGE_NOT_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    mergeS |-> (!allocS && !missStall)); // R3

  AST_ALLOC_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    allocS |-> !(&entValid)); // R2
endmodule

bind loadMissFile lmfChk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .missValid (missValid),
  .missStall (missStall),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqId     (reqId),
  .fillReady (fillReady),
  .cmplValid (cmplValid),
  .entValid  (entValid),
  .allocS    (strb.alloc),
  .mergeS    (strb.merge),
  .fillTakeS (strb.fillTake)
);

// File: tb/tb_loadMissFile.sv
module tb_loadMissFile;
  import lmfPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic                clk = 1'b0;
  logic                rstN;
  logic                missValid;
  logic [ADDR_W-1:0]   missAddr;
  logic [REG_W-1:0]    missReg;
  logic [FMT_W-1:0]    missFmt;
  logic                missStall;
  logic                reqValid;
  logic                reqReady;
  logic [ID_W-1:0]     reqId;
  logic [ADDR_W-1:0]   reqAddr;
  logic                fillValid;
  logic [ID_W-1:0]     fillId;
  logic [LINE_W-1:0]   fillData;
  logic                fillReady;
  logic                cmplValid;
  logic [REG_W-1:0]    cmplReg;
  logic [FMT_W-1:0]    cmplFmt;
  logic [WORD_OFF-1:0] cmplByte;
  logic [WORD_W-1:0]   cmplData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  loadMissFile dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missReg(missReg), .missFmt(missFmt), .missStall(missStall),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId), .reqAddr(reqAddr),
    .fillValid(fillValid), .fillId(fillId), .fillData(fillData),
    .fillReady(fillReady), .cmplValid(cmplValid), .cmplReg(cmplReg),
    .cmplFmt(cmplFmt), .cmplByte(cmplByte), .cmplData(cmplData)
  );

  int checks = 0;
  int errors = 0;

  // reference model, built from the requirements
  bit               mValid  [ENTRIES];
  bit               mFilled [ENTRIES];
  int               mBlk    [ENTRIES];
  int               mCnt    [ENTRIES];
  bit [LOADS-1:0]   mMask   [ENTRIES];
  int               mReg    [ENTRIES][LOADS];
  int               mFmt    [ENTRIES][LOADS];
  int               mSlot   [ENTRIES][LOADS];
  int               mByte   [ENTRIES][LOADS];

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int blk, input int slot, input int bo);
    return (ADDR_W'(blk) << OFF_W) | (ADDR_W'(slot) << WORD_OFF) | ADDR_W'(bo);
  endfunction

  task automatic addLoad(input int e, input int slot, input int bo, input int r, input int f);
    int k = mCnt[e];
    mReg[e][k]  = r;
    mFmt[e][k]  = f;
    mSlot[e][k] = slot;
    mByte[e][k] = bo;
    mMask[e][slot] = 1'b1;
    mCnt[e] = k + 1;
  endtask

  task automatic doMiss(input int blk, input int slot, input int bo, input int r,
                        input int f, input bit chkReq, input string tag);
    int mg = -1;
    int fr = -1;
    bit expStall;
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = mkAddr(blk, slot, bo);
    missReg   = REG_W'(r);
    missFmt   = FMT_W'(f);
    #1;
    for (int e = 0; e < ENTRIES; e++) begin
      if (mg < 0 && mValid[e] && !mFilled[e] && mBlk[e] == blk && !mMask[e][slot]) mg = e;
      if (fr < 0 && !mValid[e]) fr = e;
    end
    expStall = (mg < 0) && (fr < 0);
    chk(missStall == expStall, {tag, " R5 stall flag"}, 64'(missStall), 64'(expStall));
    if (mg >= 0) addLoad(mg, slot, bo, r, f);
    else if (fr >= 0) begin
      mValid[fr] = 1'b1; mFilled[fr] = 1'b0; mBlk[fr] = blk;
      mCnt[fr] = 0; mMask[fr] = '0;
      addLoad(fr, slot, bo, r, f);
    end
    @(negedge clk);
    missValid = 1'b0;
    if (chkReq) begin
      if (mg < 0 && fr >= 0) begin
        chk(reqValid == 1'b1, {tag, " request raised"}, 64'(reqValid), 64'd1);
        chk(reqId == ID_W'(fr), {tag, " request id"}, 64'(reqId), 64'(fr));
        chk(reqAddr == mkAddr(blk, 0, 0), {tag, " request address"},
            64'(reqAddr), 64'(mkAddr(blk, 0, 0)));
      end else begin
        chk(reqValid == 1'b0, {tag, " no request"}, 64'(reqValid), 64'd0);
      end
    end
  endtask

  function automatic logic [LINE_W-1:0] mkLine(input int id, input int seed);
    logic [LINE_W-1:0] line = '0;
    for (int w = 0; w < LOADS; w++)
      line[w*WORD_W +: WORD_W] = (64'(id) << 56) | (64'(w) << 48) |
                                 (64'(seed & 16'hFFFF) << 32) | (64'h5A00_0000 + 64'(w));
    return line;
  endfunction

  task automatic doFill(input int id, input int seed, input string tag);
    logic [LINE_W-1:0] line = mkLine(id, seed);
    bit live = (id < ENTRIES) && mValid[id] && !mFilled[id];
    int n = live ? mCnt[id] : 0;
    @(negedge clk);
    fillValid = 1'b1;
    fillId    = ID_W'(id);
    fillData  = line;
    #1;
    chk(fillReady == 1'b1, "R8 fillReady high when idle", 64'(fillReady), 64'd1);
    if (live) mFilled[id] = 1'b1;
    @(negedge clk);
    fillValid = 1'b0;
    if (live) begin
      for (int k = 0; k < n; k++) begin
        logic [63:0] expD = line[mSlot[id][k]*WORD_W +: WORD_W];
        chk(cmplValid == 1'b1, {tag, " R7 completion valid"}, 64'(cmplValid), 64'd1);
        chk(cmplReg == REG_W'(mReg[id][k]), {tag, " R7 register order"},
            64'(cmplReg), 64'(mReg[id][k]));
        chk(cmplFmt == FMT_W'(mFmt[id][k]), {tag, " R7 format"}, 64'(cmplFmt), 64'(mFmt[id][k]));
        chk(cmplByte == WORD_OFF'(mByte[id][k]), {tag, " R7 byte offset"},
            64'(cmplByte), 64'(mByte[id][k]));
        chk(cmplData == expD, {tag, " R7 quadword"}, cmplData, expD);
        chk(fillReady == 1'b0, {tag, " R8 fillReady low while draining"}, 64'(fillReady), 64'd0);
        @(negedge clk);
      end
      chk(cmplValid == 1'b0, {tag, " R7 completion count"}, 64'(cmplValid), 64'd0);
      mValid[id] = 1'b0;
      mFilled[id] = 1'b0;
    end else begin
      chk(cmplValid == 1'b0, {tag, " R10 ignored fill"}, 64'(cmplValid), 64'd0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < ENTRIES; e++) begin
      mValid[e] = 0; mFilled[e] = 0; mCnt[e] = 0; mMask[e] = '0; mBlk[e] = -1;
    end
    rstN = 1'b0; missValid = 1'b0; missAddr = '0; missReg = '0; missFmt = '0;
    reqReady = 1'b1; fillValid = 1'b0; fillId = '0; fillData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(reqValid == 1'b0,  "R1 reqValid after reset",  64'(reqValid), 64'd0);
    chk(cmplValid == 1'b0, "R1 cmplValid after reset", 64'(cmplValid), 64'd0);
    chk(missStall == 1'b0, "R1 missStall after reset", 64'(missStall), 64'd0);
    chk(fillReady == 1'b1, "R1 fillReady after reset", 64'(fillReady), 64'd1);

    // fill-up sweep: six blocks, then new block, free slot, used slot
    for (int b = 0; b < ENTRIES; b++) doMiss(b + 1, b % LOADS, b, b, b % 8, 1'b1, "R2 allocate");
    doMiss(50, 0, 1, 20, 1, 1'b1, "R5 full, new block");
    doMiss(3, 0, 2, 21, 2, 1'b1, "R3 merge while full");
    doMiss(3, 2, 3, 22, 3, 1'b1, "R4 used slot while full");
    for (int e = ENTRIES - 1; e >= 0; e--) doFill(e, 100 + e, "sweep");

    // four rotations over all slots, then a repeated slot
    for (int rot = 0; rot < LOADS; rot++) begin
      for (int k = 0; k < LOADS; k++)
        doMiss(256 + rot, (rot + k) % LOADS, k, 8 + k, k, 1'b1,
               (k == 0) ? "R8 freed entry reused" : "R3 merge free slot");
      doMiss(256 + rot, rot, 7, 20, 5, 1'b1, "R4 slot conflict new entry");
      doFill(0, rot, "rotation");
      doFill(1, rot + 10, "rotation second");
    end

    // miss to a block whose fill is draining
    doMiss(512, 0, 0, 3, 1, 1'b1, "R2 allocate");
    doMiss(512, 1, 1, 4, 2, 1'b1, "R3 merge");
    fork
      doFill(0, 77, "R9 draining entry");
      begin
        @(negedge clk);
        doMiss(512, 2, 2, 5, 3, 1'b1, "R9 no merge after fill");
      end
    join
    doFill(1, 78, "R9 follow-up");

    // fills for free and out-of-range ids
    doFill(4, 99, "R10 free id");
    doFill(7, 98, "R10 id out of range");

    // request order with the lower level not ready
    reqReady = 1'b0;
    for (int k = 0; k < 3; k++) begin
      doMiss(600 + k, 0, 0, k, 0, 1'b0, "R6 held");
      chk(reqValid == 1'b1, "R6 request pending", 64'(reqValid), 64'd1);
      chk(reqId == '0, "R6 oldest request held", 64'(reqId), 64'd0);
    end
    reqReady = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(reqValid == 1'b1, "R6 drain valid", 64'(reqValid), 64'd1);
      chk(reqId == ID_W'(k), "R6 oldest first", 64'(reqId), 64'(k));
      chk(reqAddr == mkAddr(600 + k, 0, 0), "R6 address follows id",
          64'(reqAddr), 64'(mkAddr(600 + k, 0, 0)));
      @(negedge clk);
    end
    #1;
    chk(reqValid == 1'b0, "R6 queue empty", 64'(reqValid), 64'd0);
    for (int k = 0; k < 3; k++) doFill(k, 40 + k, "R6 cleanup");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule